// File: doc/BRIEF.md
# Discrete Gaussian Random-Walk Sampler

This block draws one signed integer sample from a discrete Gaussian distribution for each request. It uses the Knuth-Yao random walk over a constant probability bit matrix of 55 rows by 109 columns. Row `r` of the matrix holds the binary expansion of the probability of magnitude `r`, and column `c` holds bit `c` of every expansion. The matrix is a parameter and is stored column by column, 7 bytes to a column. The sign is applied modulo an odd modulus `Q`, so the output is a ring coefficient ready for lattice arithmetic.

The first eight levels of the walk are resolved at once. Eight random bits address a 256-entry lookup table, which the block builds from the first eight columns of the matrix. When the lookup does not finish the walk, the walk continues from column 8. Each column is then scanned eight rows per step. A step subtracts the population count of the byte and passes over all-zero bytes without subtracting anything. Only a byte that drives the distance counter negative is searched for the exact terminating row.

Random bits arrive one at a time on a valid/ready port, and the walk waits whenever no bit is offered. The finished sample is presented on a valid/ready output. The next sample begins once that output is accepted.

Top module: `dgauss_walk_sampler`

## Requirements
- R1: After reset, `out_valid` is 0 and `rnd_ready` is 1, so the block is waiting for the first index bit of a sample.
- R2: Every sample starts by taking 8 bits, and the first bit taken becomes bit 0 of the lookup index. A lookup entry whose bit 7 is 0 ends the walk, with bits 6:0 as the magnitude, and the next bit taken is the sign.
- R3: A lookup entry whose bit 7 is 1 continues the walk at column 8, with the distance counter loaded from entry bits 6:0.
- R4: Each column from 8 onward takes exactly one fresh bit `b` and sets the distance `d` to `2d + b` before any row of that column is visited.
- R5: Within a column, rows are visited from index 54 down to 0. Each set bit lowers `d` by one, and the walk ends at the first set bit that takes `d` to -1. That row index is the magnitude.
- R6: Byte `k` of a column holds rows `8k` to `8k+7`, with row `8k+i` at bit `i`. Bit 7 of byte 6 (row 55) is always 0. Bytes are scanned from 6 down to 0, and an all-zero byte leaves `d` unchanged.
- R7: When a byte's population count `p` exceeds `d`, the terminating row is the `(p-d)`-th set bit of that byte, counted upward from its lowest row.
- R8: A sign bit of 1 gives `Q - magnitude` and a sign bit of 0 gives the magnitude. A magnitude of 0 gives 0 whatever the sign. The output is always below `Q`.
- R9: If the walk passes column 108 without ending, the output is 0 and no sign bit is taken.
- R10: A bit is taken only on a cycle with `rnd_valid` and `rnd_ready` both high. With no bit offered, the walk holds its state.
- R11: `out_sample` stays stable and `out_valid` stays high until `out_ready` is seen. While a sample is pending, `rnd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnd_valid | input | 1 | A random bit is offered |
| rnd_bit | input | 1 | The offered random bit |
| rnd_ready | output | 1 | The walk takes the offered bit this cycle |
| out_ready | input | 1 | Consumer accepts the pending sample |
| out_valid | output | 1 | A sample is pending |
| out_sample | output | $clog2(Q) | Signed sample, reduced modulo Q |

## Verification
Fixed bit patterns drive the walk down particular paths. An all-zero stream ends inside the lookup levels. A stream of ones for twelve bits and zeros after it forces the walk past column 8 and into bytes that hold more than one set bit. A stream of only ones keeps the distance at its maximum until every column is used. In the first case a design that misreads the index bit order returns the wrong magnitude. In the second, one that takes the wrong set bit within a byte, or decrements on empty bytes, is off by a few rows. In the third, one that takes a sign bit on exhaustion shifts every later sample by one bit. Pseudo-random streams with gaps in `rnd_valid` and stalls on `out_ready` are compared sample by sample against a bit-at-a-time walk. Any extra or missing bit consumption therefore shows up as a mismatch, and so does any output change during a stall.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

  localparam int DGS_ROWS  = 55;
  localparam int DGS_COLS  = 109;
  localparam int DGS_BYTES = (DGS_ROWS + 7) / 8;
  localparam int DGS_DCAP  = 5;

  typedef enum logic [2:0] {
    ST_IDX,
    ST_LUT,
    ST_COL,
    ST_SCAN,
    ST_SIGN,
    ST_OUT
  } dgs_state_e;

  // Default matrix: per column, enough set bits to keep the largest
  // reachable distance at DGS_DCAP, placed on a rotating row pattern.
  function automatic logic [DGS_COLS*DGS_BYTES*8-1:0] dgs_demo_matrix();
    logic [DGS_COLS*DGS_BYTES*8-1:0] m;
    int dmax;
    int cand;
    int k;
    int row;
    m    = '0;
    dmax = 0;
    for (int c = 0; c < DGS_COLS; c++) begin
      cand = 2 * dmax + 1;
      k    = (cand > DGS_DCAP) ? cand - DGS_DCAP : 0;
      dmax = cand - k;
      for (int j = 0; j < k; j++) begin
        row = (c * 13 + 7 * j) % DGS_ROWS;
        m[c*DGS_BYTES*8 + row] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/dgs_col_rom.sv
module dgs_col_rom #(
  parameter int N_COLS  = 109,
  parameter int N_BYTES = 7,
  parameter int COL_W   = 7,
  parameter int BYTE_W  = 3,
  parameter logic [N_COLS*N_BYTES*8-1:0] PMAT = '0
) (
  input  logic [COL_W-1:0]  col,
  input  logic [BYTE_W-1:0] bsel,
  output logic [7:0]        data
);

  always_comb begin
    if (int'(col) < N_COLS && int'(bsel) < N_BYTES) begin
      data = PMAT[(int'(col) * N_BYTES + int'(bsel)) * 8 +: 8];
    end else begin
      data = 8'h00;
    end
  end

endmodule

// File: rtl/dgs_lead_lut.sv
module dgs_lead_lut #(
  parameter int N_ROWS  = 55,
  parameter int N_COLS  = 109,
  parameter int N_BYTES = 7,
  parameter int LVL     = 8,
  parameter logic [N_COLS*N_BYTES*8-1:0] PMAT = '0
) (
  input  logic [LVL-1:0] idx,
  output logic           hit,
  output logic [LVL-2:0] val
);

  localparam int COL_BITS = N_BYTES * 8;

  // Constant-folded table: walks the first LVL columns for every index.
  always_comb begin
    int  dd;
    int  found;
    logic done;
    dd    = 0;
    found = 0;
    done  = 1'b0;
    for (int c = 0; c < LVL; c++) begin
      if (!done) begin
        dd = 2 * dd + int'(idx[c]);
      end
      for (int r = N_ROWS - 1; r >= 0; r--) begin
        if (!done && PMAT[c*COL_BITS + r]) begin
          if (dd == 0) begin
            done  = 1'b1;
            found = r;
          end else begin
            dd = dd - 1;
          end
        end
      end
    end
    hit = done;
    val = done ? (LVL-1)'(found) : (LVL-1)'(dd);
  end

endmodule

// File: rtl/dgs_byte_scan.sv
module dgs_byte_scan #(
  parameter int D_W = 8
) (
  input  logic [7:0]     byte_i,
  input  logic [D_W-1:0] d,
  output logic           zero,
  output logic [3:0]     pop,
  output logic           term,
  output logic [2:0]     pos
);

  always_comb begin
    int need;
    int seen;
    pop = 4'd0;
    for (int i = 0; i < 8; i++) begin
      pop = pop + 4'(byte_i[i]);
    end
    zero = (byte_i == 8'h00);
    term = int'(pop) > int'(d);
    need = int'(pop) - int'(d);
    seen = 0;
    pos  = 3'd0;
    for (int i = 0; i < 8; i++) begin
      if (byte_i[i]) begin
        seen = seen + 1;
        if (seen == need) begin
          pos = 3'(i);
        end
      end
    end
  end

endmodule

// File: rtl/dgauss_walk_sampler.sv
module dgauss_walk_sampler
  import dgs_pkg::*;
#(
  parameter int Q      = 7681,
  parameter int N_ROWS = 55,
  parameter int N_COLS = 109,
  parameter int LVL    = 8,
  parameter int D_W    = 8,
  parameter logic [N_COLS*((N_ROWS+7)/8)*8-1:0] PMAT = dgs_pkg::dgs_demo_matrix()
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rnd_valid,
  input  logic                 rnd_bit,
  output logic                 rnd_ready,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [$clog2(Q)-1:0] out_sample
);

  localparam int N_BYTES = (N_ROWS + 7) / 8;
  localparam int SW      = $clog2(Q);
  localparam int COL_W   = $clog2(N_COLS + 1);
  localparam int BYTE_W  = $clog2(N_BYTES);
  localparam int MAG_W   = BYTE_W + 3;
  localparam int CNT_W   = $clog2(LVL);

  dgs_state_e        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [LVL-1:0]    idx, idx_n;
  logic [D_W-1:0]    d, d_n;
  logic [COL_W-1:0]  col, col_n;
  logic [BYTE_W-1:0] bsel, bsel_n;
  logic [MAG_W-1:0]  mag, mag_n;
  logic [SW-1:0]     smp, smp_n;

  logic              lut_hit;
  logic [LVL-2:0]    lut_val;
  logic [7:0]        col_byte;
  logic              b_zero, b_term;
  logic [3:0]        b_pop;
  logic [2:0]        b_pos;
  logic              cols_done;
  logic              take;

  dgs_lead_lut #(
    .N_ROWS(N_ROWS), .N_COLS(N_COLS), .N_BYTES(N_BYTES), .LVL(LVL), .PMAT(PMAT)
  ) u_lut (
    .idx(idx), .hit(lut_hit), .val(lut_val)
  );

  dgs_col_rom #(
    .N_COLS(N_COLS), .N_BYTES(N_BYTES), .COL_W(COL_W), .BYTE_W(BYTE_W), .PMAT(PMAT)
  ) u_rom (
    .col(col), .bsel(bsel), .data(col_byte)
  );

  dgs_byte_scan #(
    .D_W(D_W)
  ) u_scan (
    .byte_i(col_byte), .d(d), .zero(b_zero), .pop(b_pop), .term(b_term), .pos(b_pos)
  );

  assign cols_done  = (col == COL_W'(N_COLS));
  assign out_valid  = (st == ST_OUT);
  assign out_sample = smp;
  assign rnd_ready  = (st == ST_IDX) || (st == ST_SIGN) || (st == ST_COL && !cols_done);
  assign take       = rnd_ready && rnd_valid;

  // Next-state logic
  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    idx_n  = idx;
    d_n    = d;
    col_n  = col;
    bsel_n = bsel;
    mag_n  = mag;
    smp_n  = smp;
    unique case (st)
      ST_IDX: begin
        if (take) begin
          idx_n[cnt] = rnd_bit;
          cnt_n      = cnt + 1'b1;
          if (cnt == CNT_W'(LVL - 1)) begin
            st_n = ST_LUT;
          end
        end
      end
      ST_LUT: begin
        if (lut_hit) begin
          mag_n = MAG_W'(lut_val);
          st_n  = ST_SIGN;
        end else begin
          d_n   = D_W'(lut_val);
          col_n = COL_W'(LVL);
          st_n  = ST_COL;
        end
      end
      ST_COL: begin
        if (cols_done) begin
          smp_n = '0;
          st_n  = ST_OUT;
        end else if (take) begin
          d_n    = {d[D_W-2:0], rnd_bit};
          bsel_n = BYTE_W'(N_BYTES - 1);
          st_n   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (!b_zero && b_term) begin
          mag_n = {bsel, b_pos};
          st_n  = ST_SIGN;
        end else begin
          if (!b_zero) begin
            d_n = d - D_W'(b_pop);
          end
          if (bsel == '0) begin
            col_n = col + 1'b1;
            st_n  = ST_COL;
          end else begin
            bsel_n = bsel - 1'b1;
          end
        end
      end
      ST_SIGN: begin
        if (take) begin
          if (rnd_bit && mag != '0) begin
            smp_n = SW'(Q) - SW'(mag);
          end else begin
            smp_n = SW'(mag);
          end
          st_n = ST_OUT;
        end
      end
      ST_OUT: begin
        if (out_ready) begin
          cnt_n = '0;
          st_n  = ST_IDX;
        end
      end
      default: st_n = ST_IDX;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDX;
      cnt  <= '0;
      idx  <= '0;
      d    <= '0;
      col  <= '0;
      bsel <= '0;
      mag  <= '0;
      smp  <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      idx  <= idx_n;
      d    <= d_n;
      col  <= col_n;
      bsel <= bsel_n;
      mag  <= mag_n;
      smp  <= smp_n;
    end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  // R11
  rdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rnd_ready);

  // R8
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_sample) < Q));

  // R6
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && col_byte == 8'h00) |=> $stable(d));

  // R7
  term_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && b_term) |-> col_byte[b_pos]);

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_ready && !rnd_valid) |=> ($stable(st) && $stable(d) && $stable(cnt) && $stable(col)));

  // R3
  lut_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LUT && !lut_hit) |=> (st == ST_COL && col == COL_W'(LVL)));

endmodule

// File: tb/dgauss_walk_sampler_tb.sv
module dgauss_walk_sampler_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int Q     = 7681;
  localparam int ROWS  = 55;
  localparam int COLS  = 109;
  localparam int BYTES = (ROWS + 7) / 8;
  localparam int CB    = BYTES * 8;
  localparam int SW    = $clog2(Q);

  function automatic logic [COLS*CB-1:0] tb_matrix();
    logic [COLS*CB-1:0] m;
    int dmax;
    int cand;
    int k;
    m    = '0;
    dmax = 0;
    for (int c = 0; c < COLS; c++) begin
      cand = 2 * dmax + 1;
      k    = (cand > 5) ? cand - 5 : 0;
      dmax = cand - k;
      for (int j = 0; j < k; j++) m[c*CB + (c * 11 + 7 * j) % ROWS] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [COLS*CB-1:0] PM = tb_matrix();

  logic clk = 1'b0;
  logic rst_n;
  logic rnd_valid, rnd_bit, rnd_ready;
  logic out_ready, out_valid;
  logic [SW-1:0] out_sample;

  always #2.5 clk = ~clk;

  dgauss_walk_sampler #(
    .Q(Q), .N_ROWS(ROWS), .N_COLS(COLS), .LVL(8), .D_W(8), .PMAT(PM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rnd_valid(rnd_valid), .rnd_bit(rnd_bit),
    .rnd_ready(rnd_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_sample(out_sample)
  );

  int    total = 0;
  int    bad   = 0;
  bit    started = 0;
  bit    finished = 0;
  bit    stream_q[$];
  int    exp_q[$];
  string tag_q[$];
  logic [15:0] lfsr = 16'hACE1;
  bit    alt = 0;
  int    scnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit gen_bit(input int mode);
    bit b;
    case (mode)
      0: b = 1'b0;
      1: b = 1'b1;
      2: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr[0];
      end
      4: b = (scnt < 12);
      default: begin
        alt = ~alt;
        b = alt;
      end
    endcase
    scnt++;
    stream_q.push_back(b);
    return b;
  endfunction

  // Driver: bit-at-a-time reference walk, pushes the expected sample
  task automatic add_sample(input int mode);
    bit ib[8];
    int d;
    int mag;
    int tcol;
    bit done;
    bit rb;
    bit s;
    scnt = 0;
    for (int i = 0; i < 8; i++) ib[i] = gen_bit(mode);
    d = 0; mag = 0; tcol = 0; done = 0;
    for (int c = 0; c < COLS && !done; c++) begin
      rb = (c < 8) ? ib[c] : gen_bit(mode);
      d  = 2 * d + int'(rb);
      for (int r = ROWS - 1; r >= 0 && !done; r--) begin
        if (PM[c*CB + r]) begin
          d--;
          if (d == -1) begin
            done = 1; mag = r; tcol = c;
          end
        end
      end
    end
    if (done) begin
      s = gen_bit(mode);
      exp_q.push_back((s && mag != 0) ? Q - mag : mag);
      tag_q.push_back(tcol < 8 ? "R2 R8 R10" : "R3 R4 R5 R6 R7 R8 R10");
    end else begin
      exp_q.push_back(0);
      tag_q.push_back("R9 R10");
    end
  endtask

  // Random-bit feeder with gaps
  int rp = 0;
  initial begin
    logic [15:0] g = 16'h1D2B;
    bit fire = 0;
    rnd_valid = 1'b0;
    rnd_bit   = 1'b0;
    forever begin
      @(negedge clk);
      if (fire) rp++;
      g = {g[14:0], g[15] ^ g[13] ^ g[12] ^ g[10]};
      rnd_valid = started && (rp < stream_q.size()) && (g[1:0] != 2'b00);
      rnd_bit   = (rp < stream_q.size()) ? stream_q[rp] : 1'b0;
      #1;
      fire = rnd_valid && rnd_ready;
    end
  end

  // Monitor / scoreboard
  initial begin
    logic [15:0] g = 16'h5A17;
    bit hold = 0;
    int held = 0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      g = {g[14:0], g[15] ^ g[13] ^ g[12] ^ g[10]};
      out_ready = started && (g[2:0] != 3'b000);
      #1;
      if (hold) begin
        // R11: pending sample held
        chk(out_valid && int'(out_sample) == held, "R11 hold", int'(out_sample), held);
        hold = 0;
      end
      if (out_valid) begin
        // R11: no bits taken while a sample is pending
        chk(!rnd_ready, "R11 ready low", int'(rnd_ready), 0);
        if (out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R10 extra sample", int'(out_sample), -1);
          end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(int'(out_sample) == e, t, int'(out_sample), e);
          end
        end else begin
          hold = 1;
          held = int'(out_sample);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) add_sample(0);
    for (int i = 0; i < 3; i++) add_sample(4);
    for (int i = 0; i < 2; i++) add_sample(1);
    for (int i = 0; i < 3; i++) add_sample(3);
    for (int i = 0; i < 60; i++) add_sample(2);
    add_sample(4);
    add_sample(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(rnd_ready == 1'b1, "R1 rnd_ready", int'(rnd_ready), 1);
    started = 1;
    wait (exp_q.size() == 0);
    repeat (20) @(negedge clk);
    #1;
    // R10: every bit of the stream was taken, none twice
    chk(rp == stream_q.size(), "R10 bits used", rp, stream_q.size());
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule